// File: doc/BRIEF.md
# Next Program Counter Unit

This unit works out where a small 8-bit controller with 16-bit instruction words fetches next when the current instruction changes the flow of control. Each cycle it receives the instruction word, the word that follows it (used only as the low half of an absolute address), the program counter already advanced past the instruction, the 8-bit flag register and the 16-bit pointer register pair. From these it produces the next program counter, a flag that says whether control left the sequential path, and the number of extra cycles the instruction costs.

Four kinds of instruction are handled. The first is a PC-relative jump with a 12-bit signed word offset. The second is a conditional branch that tests one selected flag bit, in a set form and a clear form, with a 7-bit signed offset. The third is a two-word absolute jump. The fourth is an indirect jump through the pointer pair. Any other word passes the advanced counter through unchanged. The program memory holds `2**PC_W` words. Every target is taken modulo that size by keeping only the low `PC_W` address bits, so a target below zero lands near the top of memory. All three outputs are registered, so a result appears one clock after its inputs.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the next edge shows `next_pc` = 0, `taken` = 0 and `extra_cyc` = 0.
- R2: The outputs seen after a rising edge are the function of the inputs sampled at that edge. There is exactly one register stage.
- R3: A word whose bits 15..12 are 1100 is a relative jump. `next_pc` = `pc_inc` plus bits 11..0 read as a two's-complement offset with the sign in bit 11. `taken` = 1 and `extra_cyc` = 1.
- R4: A word whose bits 15..10 are 111100 branches when flag bit `status[iw[2:0]]` is 1.
- R5: A word whose bits 15..10 are 111101 branches when flag bit `status[iw[2:0]]` is 0.
- R6: When a branch condition holds, `next_pc` = `pc_inc` plus bits 9..3 read as a signed offset (sign in bit 9, range -64..+63), with `taken` = 1 and `extra_cyc` = 1. When it fails, `next_pc` = `pc_inc`, with `taken` = 0 and `extra_cyc` = 0.
- R7: A word that matches 1001 010x xxxx 110x (mask 0xFE0E, value 0x940C) is an absolute jump. Its address is {iw[8:4], iw[0], `instr_ext`[15:0]}, a 22-bit value. `taken` = 1 and `extra_cyc` = 2.
- R8: A word that matches mask 0xFF0F with value 0x9409 is an indirect jump. The low 16 bits of the counter are replaced by `zptr`, and the bits above 16, if any, come from `pc_inc`. `taken` = 1 and `extra_cyc` = 1.
- R9: Every target is reduced modulo 2**PC_W. A negative sum wraps to the top of memory, and absolute and indirect addresses lose their bits above PC_W.
- R10: Any other word gives `next_pc` = `pc_inc`, `taken` = 0 and `extra_cyc` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_word | input | 16 | Current instruction word |
| instr_ext | input | 16 | Following word, low address half of an absolute jump |
| pc_inc | input | PC_W | Program counter already advanced past the instruction |
| status | input | 8 | Flag register |
| zptr | input | 16 | Pointer register pair, high byte times 256 plus low byte |
| next_pc | output | PC_W | Next program counter, registered |
| taken | output | 1 | Control left the sequential path, registered |
| extra_cyc | output | 2 | Extra cycles the instruction costs, registered |

## Verification
Two things can happen in the same cycle: the selected flag bit decides whether a branch is taken, and the sum of that branch wraps across address zero. The bench provokes this by giving small `pc_inc` values together with backward offsets, in both the set and the clear form, with the tested bit driven each way. A random phase mixes every instruction class with random flags and counters. On every clock a behavioural integer model checks the taken flag, the cycle count and the wrapped target all together.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [2:0] {
        K_NONE   = 3'd0,
        K_REL    = 3'd1,
        K_BRANCH = 3'd2,
        K_ABS    = 3'd3,
        K_IND    = 3'd4
    } flow_kind_e;

    typedef struct packed {
        flow_kind_e kind;
        logic       on_clear;
        logic [2:0] flag_sel;
    } flow_dec_t;

    typedef struct packed {
        logic       taken;
        logic [1:0] extra;
    } flow_cost_t;

    localparam logic [15:0] ABS_MASK = 16'hFE0E;
    localparam logic [15:0] ABS_VAL  = 16'h940C;
    localparam logic [15:0] IND_MASK = 16'hFF0F;
    localparam logic [15:0] IND_VAL  = 16'h9409;
    localparam logic [3:0]  REL_TOP  = 4'b1100;
    localparam logic [4:0]  BR_TOP   = 5'b11110;

    function automatic flow_dec_t classify(input logic [15:0] iw);
        flow_dec_t d;
        d.kind     = K_NONE;
        d.on_clear = iw[10];
        d.flag_sel = iw[2:0];
        if (iw[15:12] == REL_TOP)
            d.kind = K_REL;
        else if (iw[15:11] == BR_TOP)
            d.kind = K_BRANCH;
        else if ((iw & ABS_MASK) == ABS_VAL)
            d.kind = K_ABS;
        else if ((iw & IND_MASK) == IND_VAL)
            d.kind = K_IND;
        return d;
    endfunction

    function automatic flow_cost_t cost_of(input flow_kind_e k, input logic cond);
        flow_cost_t c;
        case (k)
            K_REL:    begin c.taken = 1'b1; c.extra = 2'd1; end
            K_BRANCH: begin c.taken = cond; c.extra = cond ? 2'd1 : 2'd0; end
            K_ABS:    begin c.taken = 1'b1; c.extra = 2'd2; end
            K_IND:    begin c.taken = 1'b1; c.extra = 2'd1; end
            default:  begin c.taken = 1'b0; c.extra = 2'd0; end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [15:0] instr_word,
    output flow_dec_t   dec
);
    always_comb begin
        dec = classify(instr_word);
    end
endmodule

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
#(
    parameter int FLAG_W = 8
) (
    input  logic [FLAG_W-1:0] status,
    input  flow_dec_t         dec,
    output logic              cond_ok
);
    logic picked;

    always_comb begin
        picked  = status[dec.flag_sel];
        cond_ok = dec.on_clear ? ~picked : picked;
    end
endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
#(
    parameter int PC_W = 14
) (
    input  logic [15:0]     instr_word,
    input  logic [15:0]     instr_ext,
    input  logic [PC_W-1:0] pc_inc,
    input  logic [15:0]     zptr,
    input  flow_kind_e      kind,
    input  logic            cond_ok,
    output logic [PC_W-1:0] target
);
    localparam int ABS_W = 22;

    logic [31:0]      rel_off32;
    logic [31:0]      br_off32;
    logic [ABS_W-1:0] abs_full;
    logic [PC_W-1:0]  rel_tgt;
    logic [PC_W-1:0]  br_tgt;
    logic [PC_W-1:0]  abs_tgt;
    logic [PC_W-1:0]  ind_tgt;

    always_comb begin
        rel_off32 = {{20{instr_word[11]}}, instr_word[11:0]};
        br_off32  = {{25{instr_word[9]}}, instr_word[9:3]};
        abs_full  = {instr_word[8:4], instr_word[0], instr_ext};
        rel_tgt   = pc_inc + rel_off32[PC_W-1:0];
        br_tgt    = pc_inc + br_off32[PC_W-1:0];
        abs_tgt   = abs_full[PC_W-1:0];
    end

    generate
        if (PC_W > 16) begin : g_ind_wide
            assign ind_tgt = {pc_inc[PC_W-1:16], zptr};
        end else begin : g_ind_narrow
            assign ind_tgt = zptr[PC_W-1:0];
        end
    endgenerate

    always_comb begin
        case (kind)
            K_REL:    target = rel_tgt;
            K_BRANCH: target = cond_ok ? br_tgt : pc_inc;
            K_ABS:    target = abs_tgt;
            K_IND:    target = ind_tgt;
            default:  target = pc_inc;
        endcase
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int PC_W = 14
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [15:0]     instr_word,
    input  logic [15:0]     instr_ext,
    input  logic [PC_W-1:0] pc_inc,
    input  logic [7:0]      status,
    input  logic [15:0]     zptr,
    output logic [PC_W-1:0] next_pc,
    output logic            taken,
    output logic [1:0]      extra_cyc
);
    flow_dec_t       dec;
    logic            cond_ok;
    logic [PC_W-1:0] target;
    flow_cost_t      cost;

    npc_decode u_dec (
        .instr_word (instr_word),
        .dec        (dec)
    );

    npc_cond #(.FLAG_W(8)) u_cond (
        .status  (status),
        .dec     (dec),
        .cond_ok (cond_ok)
    );

    npc_target #(.PC_W(PC_W)) u_tgt (
        .instr_word (instr_word),
        .instr_ext  (instr_ext),
        .pc_inc     (pc_inc),
        .zptr       (zptr),
        .kind       (dec.kind),
        .cond_ok    (cond_ok),
        .target     (target)
    );

    always_comb begin
        cost = cost_of(dec.kind, cond_ok);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            next_pc   <= '0;
            taken     <= 1'b0;
            extra_cyc <= 2'd0;
        end else begin
            next_pc   <= target;
            taken     <= cost.taken;
            extra_cyc <= cost.extra;
        end
    end
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
    parameter int PC_W = 14
) (
    input logic            clk,
    input logic            rst,
    input logic [15:0]     instr_word,
    input logic [15:0]     instr_ext,
    input logic [PC_W-1:0] pc_inc,
    input logic [7:0]      status,
    input logic [15:0]     zptr,
    input logic [PC_W-1:0] next_pc,
    input logic            taken,
    input logic [1:0]      extra_cyc
);
    localparam int LO = (PC_W < 16) ? PC_W : 16;

    p_idle_cost_r6: assert property (@(posedge clk) disable iff (rst)
        !taken |-> extra_cyc == 2'd0);

    p_taken_cost_r2: assert property (@(posedge clk) disable iff (rst)
        taken |-> extra_cyc != 2'd0);

    p_rel_cost_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(instr_word[15:12]) == 4'b1100) |-> (taken && extra_cyc == 2'd1));

    p_abs_addr_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(instr_word) & 16'hFE0E) == 16'h940C)
        |-> (extra_cyc == 2'd2 && next_pc[LO-1:0] == $past(instr_ext[LO-1:0])));

    p_ind_addr_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(instr_word) & 16'hFF0F) == 16'h9409)
        |-> (taken && next_pc[LO-1:0] == $past(zptr[LO-1:0])));

    p_pass_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(instr_word[15:12]) == 4'h0)
        |-> (!taken && next_pc == $past(pc_inc)));
endmodule

bind npc_unit npc_unit_chk #(.PC_W(PC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .instr_word (instr_word),
    .instr_ext  (instr_ext),
    .pc_inc     (pc_inc),
    .status     (status),
    .zptr       (zptr),
    .next_pc    (next_pc),
    .taken      (taken),
    .extra_cyc  (extra_cyc)
);

// File: tb/npc_unit_tb.sv
module npc_unit_tb;
    localparam int PC_W = 14;
    localparam int MEM  = 1 << PC_W;

    logic            clk = 1'b0;
    logic            rst;
    logic [15:0]     instr_word;
    logic [15:0]     instr_ext;
    logic [PC_W-1:0] pc_inc;
    logic [7:0]      status;
    logic [15:0]     zptr;
    logic [PC_W-1:0] next_pc;
    logic            taken;
    logic [1:0]      extra_cyc;

    int n_cmp  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    npc_unit #(.PC_W(PC_W)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .instr_word (instr_word),
        .instr_ext  (instr_ext),
        .pc_inc     (pc_inc),
        .status     (status),
        .zptr       (zptr),
        .next_pc    (next_pc),
        .taken      (taken),
        .extra_cyc  (extra_cyc)
    );

    function automatic int wrap(input int v);
        return ((v % MEM) + MEM) % MEM;
    endfunction

    // Behavioural model: returns {target, taken, extra} and a requirement tag.
    task automatic model(input int iw, input int ext, input int pc, input int st,
                         input int z, output int t, output int tk, output int ex,
                         output string tag);
        int off;
        int bitv;
        bit hit;
        t = pc; tk = 0; ex = 0; tag = "R10";
        if (((iw >> 12) & 15) == 12) begin
            off = iw & 12'hFFF;
            if (off >= 2048) off -= 4096;
            t = wrap(pc + off); tk = 1; ex = 1; tag = "R3";
        end else if (((iw >> 11) & 31) == 30) begin
            bitv = (st >> (iw & 7)) & 1;
            hit  = ((iw >> 10) & 1) ? (bitv == 0) : (bitv == 1);
            tag  = ((iw >> 10) & 1) ? "R5" : "R4";
            if (hit) begin
                off = (iw >> 3) & 127;
                if (off >= 64) off -= 128;
                t = wrap(pc + off); tk = 1; ex = 1;
            end
        end else if ((iw & 16'hFE0E) == 16'h940C) begin
            t = wrap((((iw >> 4) & 31) << 17) + ((iw & 1) << 16) + ext);
            tk = 1; ex = 2; tag = "R7";
        end else if ((iw & 16'hFF0F) == 16'h9409) begin
            t = wrap(z); tk = 1; ex = 1; tag = "R8";
        end
    endtask

    task automatic check(input int et, input int etk, input int eex, input string tag);
        n_cmp++;
        if (next_pc !== PC_W'(et) || taken !== etk[0] || extra_cyc !== eex[1:0]) begin
            n_fail++;
            $display("FAIL %s: got pc=%0h taken=%0d extra=%0d expected pc=%0h taken=%0d extra=%0d",
                     tag, next_pc, taken, extra_cyc, et, etk, eex);
        end
    endtask

    // Drive at a falling edge; the register captures at the rising edge; compare at the next falling edge.
    task automatic step(input int iw, input int ext, input int pc, input int st,
                        input int z, input string extra_tag);
        int t, tk, ex;
        string tag;
        instr_word = iw[15:0];
        instr_ext  = ext[15:0];
        pc_inc     = pc[PC_W-1:0];
        status     = st[7:0];
        zptr       = z[15:0];
        model(iw, ext, pc, st, z, t, tk, ex, tag);
        @(negedge clk);
        check(t, tk, ex, {tag, " ", extra_tag, " R2"});
    endtask

    initial begin
        #1500000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        instr_word = 16'hC005; instr_ext = 16'h0; pc_inc = 14'h123;
        status = 8'hFF; zptr = 16'h0;
        @(negedge clk);
        @(negedge clk);
        check(0, 0, 0, "R1 reset");
        rst = 1'b0;

        step(16'hC005, 0, 16'h0100, 0, 0, "R3 forward");
        step(16'hCFFB, 0, 3, 0, 0, "R3 R9 backward wrap");
        step(16'hC7FF, 0, 16'h0001, 0, 0, "R3 max forward");
        step(16'hF00B, 0, 16'h0200, 8'h08, 0, "R4 R6 taken");
        step(16'hF00B, 0, 16'h0200, 8'hF7, 0, "R4 R6 not taken");
        step(16'hF400 | (16'd62 << 3) | 16'd5, 0, 16'h0300, 8'h00, 0, "R5 R6 taken");
        step(16'hF405, 0, 16'h0300, 8'h20, 0, "R5 R6 not taken");
        step(16'hF200 | 16'd2, 0, 16'h0010, 8'h04, 0, "R4 R6 R9 -64 wrap");
        step(16'hF600 | (16'd127 << 3), 0, 0, 8'h00, 0, "R5 R6 R9 -1 wrap");
        step(16'h940C, 16'h1234, 0, 0, 0, "R7 low only");
        step(16'h95FD, 16'hFFFF, 0, 0, 0, "R7 R9 high bits dropped");
        step(16'h9409, 0, 16'h0055, 0, 16'h1234, "R8 pointer");
        step(16'h94F9, 0, 16'h0055, 0, 16'hC001, "R8 R9 pointer masked");
        step(16'h0000, 0, 16'h0777, 8'hFF, 16'hFFFF, "R10 nop");
        step(16'h9408, 16'hFFFF, 16'h0ABC, 8'hFF, 16'hFFFF, "R10 near match");

        for (int i = 0; i < 400; i++) begin
            int iw;
            case (i % 5)
                0: iw = 16'hC000 | ($urandom & 16'h0FFF);
                1: iw = 16'hF000 | ($urandom & 16'h07FF);
                2: iw = 16'h940C | ($urandom & 16'h01F1);
                3: iw = 16'h9409 | ($urandom & 16'h00F0);
                default: iw = $urandom & 16'hFFFF;
            endcase
            step(iw, $urandom & 16'hFFFF, $urandom % MEM, $urandom & 8'hFF,
                 $urandom & 16'hFFFF, "random");
        end

        rst = 1'b1;
        instr_word = 16'h940C; instr_ext = 16'hFFFF;
        @(negedge clk);
        check(0, 0, 0, "R1 reset again");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end
endmodule